// File: doc/BRIEF.md
# Unified Write-Back Line Cache with Uncached Windows

This block sits between a 32-bit processor memory port and a slow external DRAM. The same cache serves instruction fetches and data loads and stores; the processor issues both through one request port. The cache is direct-mapped, with 256 lines of 128 bits (4 KB). It is write-back with write-allocate. A miss fetches the whole line in one 128-bit beat over a request/acknowledge memory port. When the victim line is dirty, one 128-bit writeback beat goes out first.

Two fixed address ranges belong to on-chip memories and are never cached. The range 0x10000000–0x1001FFFF (128 KB graphics memory) goes straight to bypass port 0. The range 0x20000000–0x2000FFFF (64 KB audio/boot memory) goes straight to bypass port 1. This holds for fetches, loads and stores alike. Every other address goes through the cache.

The processor raises `cpu_req` for one cycle while `cpu_busy` is low. It then waits for the one-cycle `cpu_ack` pulse, which carries read data on `cpu_rdata`.

Top module: `uline_cache`

## Requirements
- R1: The cache is direct-mapped with 256 lines of 128 bits. Address bits [3:2] select the 32-bit word, bits [11:4] the line and bits [31:12] the tag. A read hit raises `cpu_ack` with the word one cycle after the request and starts no memory beat.
- R2: A miss on an invalid or clean line issues exactly one read beat (`mem_we`=0) for line address `cpu_addr[31:4]`. No writeback beat precedes it. `cpu_ack` rises the cycle after `mem_ack` and carries the requested word of the fetched line.
- R3: Stores merge byte lanes: `cpu_be[i]` set writes `cpu_wdata[8i+7:8i]`, and a clear bit keeps the old byte. A store hit starts no memory beat. A store miss first fills the line (write-allocate) and then merges.
- R4: A miss on a dirty line first issues one writeback beat (`mem_we`=1) carrying the victim's line address and its full 128-bit contents, with word k in bits [32k+31:32k]. One read beat follows.
- R5: Any access in 0x10000000–0x1001FFFF raises only `byp_req[0]`, starts no memory beat and is never cached, so a repeated read goes to the port again.
- R6: Any access in 0x20000000–0x2000FFFF raises only `byp_req[1]`, with the same uncached behaviour.
- R7: `cpu_busy` is high from the cycle after an accepted request until the ack cycle, and low the cycle after. A `cpu_req` raised while busy is ignored.
- R8: Reset clears every valid and dirty bit. The first access to any line afterwards is a miss with no writeback.
- R9: `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.
- R10: For a bypass access, the shared `byp_addr`, `byp_we`, `byp_be` and `byp_wdata` carry the request unchanged. `cpu_ack` and `cpu_rdata` follow the selected port's `byp_ack` and `byp_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Request strobe, sampled while not busy |
| cpu_we | input | 1 | 1 = store, 0 = fetch/load |
| cpu_be | input | 4 | Store byte enables |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Request in progress |
| mem_req | output | 1 | External beat request |
| mem_we | output | 1 | 1 = writeback beat, 0 = fill beat |
| mem_addr | output | 28 | Line address (byte address bits 31:4) |
| mem_wdata | output | 128 | Writeback line |
| mem_rdata | input | 128 | Fill line, valid with mem_ack |
| mem_ack | input | 1 | Beat done |
| byp_req | output | 2 | Per-window request |
| byp_we | output | 1 | Bypass store |
| byp_be | output | 4 | Bypass byte enables |
| byp_addr | output | 32 | Bypass byte address |
| byp_wdata | output | 32 | Bypass store data |
| byp_rdata | input | 2x32 | Per-window read data |
| byp_ack | input | 2 | Per-window completion |

## Verification
Each result has a fixed due cycle. A hit's ack is due at the first falling edge after the request edge. A miss's ack is due one cycle after the last fill `mem_ack`. A bypass ack arrives in the same cycle as the port's ack. The bench drives inputs on falling edges and samples 1 ns later. It counts falling edges until the ack and requires exactly one for predicted hits. It also counts the memory and bypass beats each access triggers, and compares them with a bench-side model of tags, valid and dirty bits.

// File: rtl/uc_pkg.sv
package uc_pkg;
   typedef enum logic [2:0] {
      UC_IDLE,
      UC_LOOKUP,
      UC_EVICT,
      UC_REFILL,
      UC_DIRECT
   } uc_state_e;
endpackage

// File: rtl/uc_window_decode.sv
module uc_window_decode #(
   parameter int AW      = 32,
   parameter int NUM_WIN = 2,
   parameter logic [NUM_WIN-1:0][AW-1:0] WIN_BASE = {32'h2000_0000, 32'h1000_0000},
   parameter logic [NUM_WIN-1:0][AW-1:0] WIN_SIZE = {32'h0001_0000, 32'h0002_0000}
) (
   input  logic [AW-1:0]      addr,
   output logic [NUM_WIN-1:0] in_win
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [AW-1:0] SZ   = WIN_SIZE[w];
      localparam logic [AW-1:0] MASK = ~(SZ - 1'b1);
      if ((SZ & (SZ - 1'b1)) != '0) begin : g_bad_size
         $error("window size must be a power of two");
      end
      if ((WIN_BASE[w] & ~MASK) != '0) begin : g_bad_base
         $error("window base must be aligned to its size");
      end
      assign in_win[w] = (addr & MASK) == WIN_BASE[w];
   end
endmodule

// File: rtl/uc_tag_store.sv
module uc_tag_store #(
   parameter int LINES = 256,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] q_tag,
   output logic             q_valid,
   output logic             q_dirty,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             set_dirty
);
   logic [LINES-1:0] valid_r;
   logic [LINES-1:0] dirty_r;
   logic [TAG_W-1:0] tag_r [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_r <= '0;
         dirty_r <= '0;
      end else if (fill_en) begin
         valid_r[idx] <= 1'b1;
         dirty_r[idx] <= 1'b0;
      end else if (set_dirty) begin
         dirty_r[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_r[idx] <= fill_tag;
   end

   assign q_tag   = tag_r[idx];
   assign q_valid = valid_r[idx];
   assign q_dirty = dirty_r[idx];

   AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      q_dirty |-> q_valid); // R8
endmodule

// File: rtl/uc_data_store.sv
module uc_data_store #(
   parameter int LINES  = 256,
   parameter int LINE_W = 128,
   parameter int WORD_W = 32,
   localparam int IDX_W = $clog2(LINES),
   localparam int WORDS = LINE_W / WORD_W,
   localparam int SEL_W = $clog2(WORDS),
   localparam int BE_W  = WORD_W / 8
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   output logic [LINE_W-1:0] line_q,
   input  logic              fill_en,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [WORD_W-1:0] wr_data
);
   logic [LINE_W-1:0] mem [LINES];

   always_ff @(posedge clk) begin
      if (fill_en) begin
         mem[idx] <= fill_line;
      end else if (wr_en) begin
         for (int b = 0; b < BE_W; b++) begin
            if (wr_be[b]) mem[idx][int'(wr_sel)*WORD_W + b*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   assign line_q = mem[idx];
endmodule

// File: rtl/uline_cache.sv
module uline_cache
   import uc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int WORD_W    = 32,
   parameter int LINE_W    = 128,
   parameter int NUM_LINES = 256,
   parameter int NUM_WIN   = 2,
   parameter logic [NUM_WIN-1:0][AW-1:0] WIN_BASE = {32'h2000_0000, 32'h1000_0000},
   parameter logic [NUM_WIN-1:0][AW-1:0] WIN_SIZE = {32'h0001_0000, 32'h0002_0000},
   localparam int BE_W    = WORD_W / 8,
   localparam int WORDS   = LINE_W / WORD_W,
   localparam int BOFF_W  = $clog2(BE_W),
   localparam int SEL_W   = $clog2(WORDS),
   localparam int OFF_W   = $clog2(LINE_W / 8),
   localparam int IDX_W   = $clog2(NUM_LINES),
   localparam int TAG_W   = AW - IDX_W - OFF_W,
   localparam int LADDR_W = AW - OFF_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cpu_req,
   input  logic                           cpu_we,
   input  logic [BE_W-1:0]                cpu_be,
   input  logic [AW-1:0]                  cpu_addr,
   input  logic [WORD_W-1:0]              cpu_wdata,
   output logic [WORD_W-1:0]              cpu_rdata,
   output logic                           cpu_ack,
   output logic                           cpu_busy,
   output logic                           mem_req,
   output logic                           mem_we,
   output logic [LADDR_W-1:0]             mem_addr,
   output logic [LINE_W-1:0]              mem_wdata,
   input  logic [LINE_W-1:0]              mem_rdata,
   input  logic                           mem_ack,
   output logic [NUM_WIN-1:0]             byp_req,
   output logic                           byp_we,
   output logic [BE_W-1:0]                byp_be,
   output logic [AW-1:0]                  byp_addr,
   output logic [WORD_W-1:0]              byp_wdata,
   input  logic [NUM_WIN-1:0][WORD_W-1:0] byp_rdata,
   input  logic [NUM_WIN-1:0]             byp_ack
);
   if (LINE_W % WORD_W != 0 || WORDS < 2) begin : g_bad_line
      $error("line must hold at least two whole words");
   end
   if ((NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("line count must be a power of two");
   end
   if (WORD_W % 8 != 0) begin : g_bad_word
      $error("word width must be whole bytes");
   end

   uc_state_e          state;
   logic               r_we;
   logic [BE_W-1:0]    r_be;
   logic [AW-1:0]      r_addr;
   logic [WORD_W-1:0]  r_wdata;
   logic [NUM_WIN-1:0] r_win;
   logic [NUM_WIN-1:0] dec_win;

   logic [IDX_W-1:0]   idx;
   logic [TAG_W-1:0]   tag;
   logic [SEL_W-1:0]   wsel;
   logic [TAG_W-1:0]   t_tag;
   logic               t_valid;
   logic               t_dirty;
   logic               hit;
   logic [LINE_W-1:0]  line_q;
   logic               refill_done;
   logic               direct_done;
   logic [WORD_W-1:0]  direct_word;

   assign idx  = r_addr[OFF_W +: IDX_W];
   assign tag  = r_addr[AW-1 -: TAG_W];
   assign wsel = r_addr[BOFF_W +: SEL_W];

   uc_window_decode #(.AW(AW), .NUM_WIN(NUM_WIN), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_dec (
      .addr(cpu_addr), .in_win(dec_win));

   uc_tag_store #(.LINES(NUM_LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(idx), .q_tag(t_tag), .q_valid(t_valid), .q_dirty(t_dirty),
      .fill_en(refill_done), .fill_tag(tag), .set_dirty(state == UC_LOOKUP && hit && r_we));

   uc_data_store #(.LINES(NUM_LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_data (
      .clk(clk), .idx(idx), .line_q(line_q), .fill_en(refill_done), .fill_line(mem_rdata),
      .wr_en(state == UC_LOOKUP && hit && r_we), .wr_sel(wsel), .wr_be(r_be), .wr_data(r_wdata));

   assign hit         = t_valid && (t_tag == tag);
   assign refill_done = (state == UC_REFILL) && mem_ack;
   assign direct_done = (state == UC_DIRECT) && |(byp_ack & r_win);

   always_comb begin
      direct_word = '0;
      for (int w = 0; w < NUM_WIN; w++) begin
         if (r_win[w]) direct_word = byp_rdata[w];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= UC_IDLE;
         r_we    <= 1'b0;
         r_be    <= '0;
         r_addr  <= '0;
         r_wdata <= '0;
         r_win   <= '0;
      end else begin
         unique case (state)
            UC_IDLE: if (cpu_req) begin
               r_we    <= cpu_we;
               r_be    <= cpu_be;
               r_addr  <= cpu_addr;
               r_wdata <= cpu_wdata;
               r_win   <= dec_win;
               state   <= (|dec_win) ? UC_DIRECT : UC_LOOKUP;
            end
            UC_LOOKUP: begin
               if (hit)                  state <= UC_IDLE;
               else if (t_valid && t_dirty) state <= UC_EVICT;
               else                      state <= UC_REFILL;
            end
            UC_EVICT:  if (mem_ack)     state <= UC_REFILL;
            UC_REFILL: if (mem_ack)     state <= UC_LOOKUP;
            UC_DIRECT: if (direct_done) state <= UC_IDLE;
            default:                    state <= UC_IDLE;
         endcase
      end
   end

   assign cpu_busy  = (state != UC_IDLE);
   assign cpu_ack   = (state == UC_LOOKUP && hit) || direct_done;
   assign cpu_rdata = (state == UC_DIRECT) ? direct_word : line_q[int'(wsel)*WORD_W +: WORD_W];

   assign mem_req   = (state == UC_EVICT) || (state == UC_REFILL);
   assign mem_we    = (state == UC_EVICT);
   assign mem_addr  = (state == UC_EVICT) ? {t_tag, idx} : {tag, idx};
   assign mem_wdata = line_q;

   assign byp_req   = (state == UC_DIRECT) ? r_win : '0;
   assign byp_we    = r_we;
   assign byp_be    = r_be;
   assign byp_addr  = r_addr;
   assign byp_wdata = r_wdata;

   AST_DIRECT_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(byp_req)); // R5
   AST_DIRECT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (|byp_req) |-> !mem_req); // R6
   AST_MEM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
   AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> mem_req && !mem_we); // R4
   AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |=> !cpu_busy); // R7
   AST_NO_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> !cpu_ack); // R7
endmodule

// File: tb/uline_cache_test.sv
module uline_cache_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              cpu_req = 1'b0, cpu_we = 1'b0;
   logic [3:0]        cpu_be = 4'h0;
   logic [31:0]       cpu_addr = '0, cpu_wdata = '0;
   logic [31:0]       cpu_rdata;
   logic              cpu_ack, cpu_busy;
   logic              mem_req, mem_we;
   logic [27:0]       mem_addr;
   logic [127:0]      mem_wdata;
   logic [127:0]      mem_rdata = '0;
   logic              mem_ack = 1'b0;
   logic [1:0]        byp_req;
   logic              byp_we;
   logic [3:0]        byp_be;
   logic [31:0]       byp_addr, byp_wdata;
   logic [1:0][31:0]  byp_rdata = '0;
   logic [1:0]        byp_ack = '0;

   uline_cache uut (.*);

   int tests = 0, fails = 0;
   int wb_cnt = 0, rd_cnt = 0;
   int bp_cnt [2] = '{0, 0};
   logic [27:0]  last_wb_addr, last_rd_addr;
   logic [127:0] last_wb_data;
   logic [127:0] dram [logic [27:0]];
   logic [31:0]  onchip [logic [31:0]];
   logic [31:0]  ref_m [logic [31:0]];
   logic [19:0]  m_tag [256];
   logic         m_val [256];
   logic         m_dirty [256];

   function automatic logic [31:0] patw(input logic [31:0] a);
      return ((a >> 2) * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:0] ref_get(input logic [31:0] a);
      return ref_m.exists(a) ? ref_m[a] : patw(a);
   endfunction

   function automatic logic [127:0] line_get(input logic [27:0] la);
      logic [127:0] l;
      if (dram.exists(la)) return dram[la];
      for (int i = 0; i < 4; i++) l[i*32 +: 32] = patw({la, 4'h0} + 32'(i * 4));
      return l;
   endfunction

   function automatic bit in_w0(input logic [31:0] a);
      return a >= 32'h1000_0000 && a < 32'h1002_0000;
   endfunction
   function automatic bit in_w1(input logic [31:0] a);
      return a >= 32'h2000_0000 && a < 32'h2001_0000;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // external DRAM responder
   int mdly = 0;
   always @(negedge clk) begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
         if (mdly == 0) begin
            if (mem_we) begin
               dram[mem_addr] = mem_wdata;
               last_wb_addr = mem_addr; last_wb_data = mem_wdata; wb_cnt++;
            end else begin
               mem_rdata = line_get(mem_addr);
               last_rd_addr = mem_addr; rd_cnt++;
            end
            mem_ack = 1'b1;
            mdly = $urandom % 3;
         end else mdly--;
      end
   end

   // on-chip window responders
   int bdly = 0;
   always @(negedge clk) begin
      if (byp_ack != 0) byp_ack = '0;
      else if (byp_req != 0) begin
         if (bdly == 0) begin
            for (int w = 0; w < 2; w++) begin
               if (byp_req[w]) begin
                  logic [31:0] cur;
                  cur = onchip.exists(byp_addr) ? onchip[byp_addr] : patw(byp_addr);
                  if (byp_we) onchip[byp_addr] = merge(cur, byp_wdata, byp_be);
                  byp_rdata[w] = cur;
                  bp_cnt[w]++;
               end
            end
            byp_ack = byp_req;
            bdly = $urandom % 3;
         end else bdly--;
      end
   end

   task automatic access(input bit we, input logic [3:0] be, input logic [31:0] a,
                         input logic [31:0] wd, input bit poke,
                         output logic [31:0] rd, output int cyc);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = a; cpu_wdata = wd;
      cyc = 0; rd = 'x;
      forever begin
         @(negedge clk);
         cpu_req = 1'b0;
         #1;
         cyc++;
         if (cpu_ack) begin rd = cpu_rdata; break; end
         if (cyc > 400) break;
         if (poke && cyc == 1 && cpu_busy) begin
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_be = 4'hF;
            cpu_addr = 32'h0000_1230; cpu_wdata = 32'h0BAD_F00D;
         end
      end
   endtask

   // full access with model prediction and checks
   task automatic op(input bit we, input logic [3:0] be, input logic [31:0] a,
                     input logic [31:0] wd, input bit poke);
      logic [31:0] rd, expv;
      int cyc, wb0, rd0, b0, b1;
      bit byp0, byp1, hitp, wbp;
      logic [7:0] ix;
      logic [19:0] tg;
      byp0 = in_w0(a); byp1 = in_w1(a);
      ix = a[11:4]; tg = a[31:12];
      hitp = m_val[ix] && m_tag[ix] == tg;
      wbp  = m_val[ix] && m_dirty[ix] && !hitp;
      expv = ref_get(a);
      wb0 = wb_cnt; rd0 = rd_cnt; b0 = bp_cnt[0]; b1 = bp_cnt[1];
      access(we, be, a, wd, poke, rd, cyc);
      chk(cyc <= 400, "R7", "ack arrives", cyc, 0);
      if (!we) chk(rd === expv, byp0 ? "R5" : byp1 ? "R6" : "R1", "read data", rd, expv);
      if (we) ref_m[a] = merge(expv, wd, be);
      if (byp0 || byp1) begin
         chk(wb_cnt == wb0 && rd_cnt == rd0, byp0 ? "R5" : "R6", "no DRAM beat in window",
             (wb_cnt - wb0) + (rd_cnt - rd0), 0);
         chk(bp_cnt[0] - b0 == int'(byp0) && bp_cnt[1] - b1 == int'(byp1), "R10", "port routing",
             {bp_cnt[1] - b1, bp_cnt[0] - b0}, {int'(byp1), int'(byp0)});
         if (we) chk(onchip[a] === ref_m[a], "R10", "bypass store lanes", onchip[a], ref_m[a]);
      end else begin
         if (hitp) begin
            chk(cyc == 1, "R1", "hit latency", cyc, 1);
            chk(wb_cnt == wb0 && rd_cnt == rd0, we ? "R3" : "R1", "hit has no beat",
                (wb_cnt - wb0) + (rd_cnt - rd0), 0);
         end else begin
            chk(rd_cnt - rd0 == 1, "R2", "one fill beat", rd_cnt - rd0, 1);
            chk(last_rd_addr == a[31:4], "R2", "fill line address", last_rd_addr, a[31:4]);
            chk(wb_cnt - wb0 == int'(wbp), wbp ? "R4" : "R8", "writeback count", wb_cnt - wb0, int'(wbp));
            if (wbp) chk(last_wb_addr == {m_tag[ix], ix}, "R4", "victim address",
                         last_wb_addr, {m_tag[ix], ix});
            m_val[ix] = 1'b1; m_tag[ix] = tg; m_dirty[ix] = 1'b0;
         end
         if (we) m_dirty[ix] = 1'b1;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] rd, a, wd;
      int cyc;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) begin m_val[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
      repeat (3) @(posedge clk);
      #1;
      chk(!cpu_busy && !cpu_ack && !mem_req && byp_req == 0, "R8", "reset idle outputs",
          {cpu_busy, cpu_ack, mem_req, byp_req}, 0);
      rst_n = 1'b1;

      // directed
      op(0, 4'h0, 32'h0000_1230, 0, 0);                 // R2, R8 cold miss
      op(0, 4'h0, 32'h0000_1230, 0, 0);                 // R1 hit
      op(1, 4'b0101, 32'h0000_1230, 32'hDEAD_BEEF, 0);  // R3 store hit
      op(0, 4'h0, 32'h0000_1230, 0, 0);                 // R3 merged read
      op(0, 4'h0, 32'h0000_1234, 0, 0);                 // R1 other word in line
      wd = ref_get(32'h0000_1230);
      op(0, 4'h0, 32'h0000_2230, 0, 0);                 // R4 dirty eviction
      chk(last_wb_data[31:0] === wd, "R4", "victim word 0 written back", last_wb_data[31:0], wd);
      op(0, 4'h0, 32'h0000_1230, 0, 0);                 // R4 data survives eviction
      op(1, 4'b1000, 32'h0000_344C, 32'hAB00_0000, 0);  // R3 store miss allocates
      op(0, 4'h0, 32'h0000_344C, 0, 0);
      op(0, 4'h0, 32'h0000_5670, 0, 1);                 // R7 request while busy ignored
      @(negedge clk); #1;
      chk(!cpu_busy, "R7", "idle after ack", cpu_busy, 0);
      op(0, 4'h0, 32'h0000_1230, 0, 0);                 // R7 poked store had no effect
      op(0, 4'h0, 32'h1001_FFFC, 0, 0);                 // R5
      op(1, 4'b0011, 32'h1001_FFFC, 32'h1234_5678, 0);
      op(0, 4'h0, 32'h1001_FFFC, 0, 0);
      op(0, 4'h0, 32'h2000_0000, 0, 0);                 // R6
      op(1, 4'b1100, 32'h2000_FFFC, 32'h8765_4321, 0);
      op(0, 4'h0, 32'h2000_FFFC, 0, 0);
      op(0, 4'h0, 32'h1002_0000, 0, 0);                 // R1 just past window: cached
      op(0, 4'h0, 32'h1002_0000, 0, 0);

      // constrained random
      for (int n = 0; n < 1500; n++) begin
         int k;
         logic [19:0] tg;
         k = $urandom % 10;
         case ($urandom % 4)
            0: tg = 20'h00001; 1: tg = 20'h00002; 2: tg = 20'h0A5A5; default: tg = 20'hFFFF0;
         endcase
         if (k == 0)      a = 32'h1000_0000 + (($urandom % 16) << 2) + 32'h0001_FF00;
         else if (k == 1) a = 32'h2000_0000 + (($urandom % 16) << 2);
         else             a = {tg, 4'h0, 4'($urandom % 4), 2'($urandom), 2'b00};
         op(1'($urandom), 4'($urandom), a, $urandom, 0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule